// File: doc/BRIEF.md
# Edge-Capturing GPIO Port with Byte-Swapped Register Access

This block is a 16-pin general-purpose I/O port controlled through a small synchronous register interface. Each pin can be an input or an output. Software sets the direction and the output level, and it reads back the pin levels after they pass through a two-flop synchronizer. Every pin can report rising and falling transitions separately. Each polarity has its own enable mask and its own sticky status register, and software clears status bits by writing ones to them.

The register file is big-endian. Every value therefore crosses the bus with its two bytes exchanged, in both the write and the read direction. A single registered interrupt line is high while any status bit is set whose matching enable bit is also set. A host interrupt controller watches that line and reads the status registers to find the cause.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every register reads zero, `pin_oe` and `pin_out` are zero and `irq` is low.
- R2: Bus data is byte-swapped in both directions: bus bits 7:0 carry register bits 15:8, and bus bits 15:8 carry register bits 7:0. Register addresses: 0 direction, 1 output data, 2 input data (read-only), 3 rising enable, 4 falling enable, 5 rising status, 6 falling status. Address 7 reads zero.
- R3: `pin_oe` equals the direction register (1 means output) and `pin_out` equals the output data register.
- R4: The input data register returns the synchronized pin levels. A pin change appears there two clock edges after it is applied, and it can set a status bit no earlier than the edge after that.
- R5: A rising edge on a pin whose rising-enable bit is 1 sets the matching rising-status bit. A falling edge never sets a rising-status bit.
- R6: A falling edge on a pin whose falling-enable bit is 1 sets the matching falling-status bit.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: While an enable bit is 0, edges on that pin set no new status bit. Status bits that are already set stay set.
- R9: If an edge is detected on the same clock edge as a write-one-to-clear of that status bit, the bit stays 1.
- R10: `irq` is registered. One edge after the fact, it equals the OR over all pins of (rising status AND rising enable) OR (falling status AND falling enable).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data (byte-swapped) |
| bus_rdata | output | 16 | Read data for `bus_addr` (byte-swapped, combinational) |
| pin_in | input | 16 | Pad input levels |
| pin_out | output | 16 | Pad output levels |
| pin_oe | output | 16 | Pad output enables |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is an edge detection that coincides exactly with a write-one-to-clear of the same status bit. The detection happens a fixed number of edges after the pin moves, so the stimulus counts edges from the pin change and places the write strobe on the edge where the status bit is set. Before that, it sets the bit once through an earlier edge, so the clear would have had a visible effect if it had won. The stimulus also checks the synchronizer latency edge by edge: the input register and the status register are read at each edge after a pin change.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int ADDR_W = 3;

    // Register map; the bench and software depend on these values.
    typedef enum logic [ADDR_W-1:0] {
        RA_DIR     = 3'd0,
        RA_DOUT    = 3'd1,
        RA_DIN     = 3'd2,
        RA_RISE_EN = 3'd3,
        RA_FALL_EN = 3'd4,
        RA_RISE_ST = 3'd5,
        RA_FALL_ST = 3'd6,
        RA_NONE    = 3'd7
    } reg_addr_e;

    // Per-pin transition event after synchronization.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

endpackage

// File: rtl/gpio_lane_swap.sv
module gpio_lane_swap #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int NBYTES = WIDTH / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign dout[b*8 +: 8] = din[(NBYTES-1-b)*8 +: 8];
    end
endmodule

// File: rtl/gpio_sync_edge.sv
module gpio_sync_edge
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [WIDTH-1:0]      pin_in,
    output logic [WIDTH-1:0]      level,
    output edge_evt_t [WIDTH-1:0] evt
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_in[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign level[i]    = sync_q;
        assign evt[i].rise = sync_q & ~prev_q;
        assign evt[i].fall = ~sync_q & prev_q;
    end
endmodule

// File: rtl/gpio_sticky_status.sv
module gpio_sticky_status #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] hit,
    input  logic [WIDTH-1:0] enable,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] status
);
    logic [WIDTH-1:0] clr_eff;
    logic [WIDTH-1:0] set_eff;

    always_comb begin
        clr_eff = clr_we ? clr_mask : '0;
        set_eff = hit & enable;
    end

    // A new event takes priority over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_eff) | set_eff;
    end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe,
    output logic              irq
);
    logic [WIDTH-1:0] wr_val;
    logic [WIDTH-1:0] rd_val;
    logic [WIDTH-1:0] dir_q, dout_q, rise_en_q, fall_en_q;
    logic [WIDTH-1:0] din_lvl, rise_hit, fall_hit;
    logic [WIDTH-1:0] rise_st, fall_st;
    edge_evt_t [WIDTH-1:0] evt;
    logic irq_q;
    reg_addr_e addr_e;

    assign addr_e = reg_addr_e'(bus_addr);

    gpio_lane_swap #(.WIDTH(WIDTH)) u_wswap (.din(bus_wdata), .dout(wr_val));
    gpio_lane_swap #(.WIDTH(WIDTH)) u_rswap (.din(rd_val),    .dout(bus_rdata));

    gpio_sync_edge #(.WIDTH(WIDTH)) u_sync (
        .clk(clk), .rst(rst), .pin_in(pin_in), .level(din_lvl), .evt(evt)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_split
        assign rise_hit[i] = evt[i].rise;
        assign fall_hit[i] = evt[i].fall;
    end

    gpio_sticky_status #(.WIDTH(WIDTH)) u_rise_st (
        .clk(clk), .rst(rst), .hit(rise_hit), .enable(rise_en_q),
        .clr_we(bus_we && addr_e == RA_RISE_ST), .clr_mask(wr_val),
        .status(rise_st)
    );

    gpio_sticky_status #(.WIDTH(WIDTH)) u_fall_st (
        .clk(clk), .rst(rst), .hit(fall_hit), .enable(fall_en_q),
        .clr_we(bus_we && addr_e == RA_FALL_ST), .clr_mask(wr_val),
        .status(fall_st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q     <= '0;
            dout_q    <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (bus_we) begin
            case (addr_e)
                RA_DIR:     dir_q     <= wr_val;
                RA_DOUT:    dout_q    <= wr_val;
                RA_RISE_EN: rise_en_q <= wr_val;
                RA_FALL_EN: fall_en_q <= wr_val;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr_e)
            RA_DIR:     rd_val = dir_q;
            RA_DOUT:    rd_val = dout_q;
            RA_DIN:     rd_val = din_lvl;
            RA_RISE_EN: rd_val = rise_en_q;
            RA_FALL_EN: rd_val = fall_en_q;
            RA_RISE_ST: rd_val = rise_st;
            RA_FALL_ST: rd_val = fall_st;
            default:    rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |((rise_st & rise_en_q) | (fall_st & fall_en_q));
    end

    assign irq     = irq_q;
    assign pin_out = dout_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  rise_st,
    input logic [WIDTH-1:0]  fall_st,
    input logic [WIDTH-1:0]  rise_en,
    input logic [WIDTH-1:0]  fall_en,
    input logic              irq
);
    // R1
    reset_irq_low_chk: assert property (@(posedge clk) rst |=> !irq);

    // R3
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == RA_DIR) |=> $stable(pin_oe));

    // R7
    rise_clear_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == RA_RISE_ST) |=> (($past(rise_st) & ~rise_st) == '0));

    // R7
    fall_clear_only_by_write_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == RA_FALL_ST) |=> (($past(fall_st) & ~fall_st) == '0));

    // R8
    rise_masked_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rise_st & ~$past(rise_st) & ~$past(rise_en)) == '0));

    // R8
    fall_masked_no_set_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((fall_st & ~$past(fall_st) & ~$past(fall_en)) == '0));

    // R10
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|(rise_st | fall_st)));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .pin_oe(pin_oe), .rise_st(rise_st), .fall_st(fall_st),
    .rise_en(rise_en_q), .fall_en(fall_en_q), .irq(irq)
);

// File: tb/test_gpio_edge_port.sv
module test_gpio_edge_port;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PIN = 2'd2, OP_IRQ = 2'd3;
    localparam int NV = 33;

    // {req, op, addr, data}; data is bus form for WR/RD, pin value for PIN, irq for IRQ.
    localparam logic [24:0] VEC [NV] = '{
        {4'd3,  OP_WR,  3'd0, 16'h3412},  // R3 direction = 0x1234
        {4'd2,  OP_RD,  3'd0, 16'h3412},  // R2
        {4'd3,  OP_WR,  3'd1, 16'hCDAB},  // R3 output = 0xABCD
        {4'd2,  OP_RD,  3'd1, 16'hCDAB},  // R2
        {4'd5,  OP_WR,  3'd3, 16'h0100},  // R5 rise enable bit0
        {4'd6,  OP_WR,  3'd4, 16'h0002},  // R6 fall enable bit9
        {4'd2,  OP_RD,  3'd3, 16'h0100},  // R2
        {4'd2,  OP_RD,  3'd7, 16'h0000},  // R2 unused address
        {4'd5,  OP_PIN, 3'd0, 16'h0001},  // R5 bit0 rises
        {4'd5,  OP_RD,  3'd5, 16'h0100},  // R5
        {4'd5,  OP_RD,  3'd6, 16'h0000},  // R5
        {4'd10, OP_IRQ, 3'd0, 16'h0001},  // R10
        {4'd5,  OP_PIN, 3'd0, 16'h0201},  // R5 bit9 rises, not enabled
        {4'd5,  OP_RD,  3'd5, 16'h0100},  // R5
        {4'd6,  OP_PIN, 3'd0, 16'h0001},  // R6 bit9 falls
        {4'd6,  OP_RD,  3'd6, 16'h0002},  // R6
        {4'd4,  OP_RD,  3'd2, 16'h0100},  // R4
        {4'd7,  OP_WR,  3'd5, 16'h0000},  // R7 zeros leave bits
        {4'd7,  OP_RD,  3'd5, 16'h0100},  // R7
        {4'd7,  OP_WR,  3'd5, 16'h0100},  // R7 clear bit0
        {4'd7,  OP_RD,  3'd5, 16'h0000},  // R7
        {4'd10, OP_IRQ, 3'd0, 16'h0001},  // R10 fall status still enabled
        {4'd8,  OP_WR,  3'd4, 16'h0000},  // R8 disable falls
        {4'd10, OP_IRQ, 3'd0, 16'h0000},  // R10 masked
        {4'd8,  OP_RD,  3'd6, 16'h0002},  // R8 status kept
        {4'd7,  OP_WR,  3'd6, 16'h0002},  // R7
        {4'd7,  OP_RD,  3'd6, 16'h0000},  // R7
        {4'd8,  OP_PIN, 3'd0, 16'h0201},  // R8
        {4'd8,  OP_PIN, 3'd0, 16'h0001},  // R8 fall while disabled
        {4'd8,  OP_RD,  3'd6, 16'h0000},  // R8
        {4'd5,  OP_PIN, 3'd0, 16'h0000},  // R5 bit0 falls
        {4'd5,  OP_RD,  3'd5, 16'h0000},  // R5
        {4'd10, OP_IRQ, 3'd0, 16'h0000}   // R10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic        irq;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_edge_port i_gpio_edge_port (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic drive_pins(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 pin_oe", pin_oe, 16'h0);
        chk("R1 pin_out", pin_out, 16'h0);
        chk("R1 irq", {15'd0, irq}, 16'h0);
        for (int a = 0; a < 8; a++) rd("R1 reg", 3'(a), 16'h0);

        for (int v = 0; v < NV; v++) begin
            logic [3:0]  rq;
            logic [1:0]  op;
            logic [2:0]  ad;
            logic [15:0] dt;
            {rq, op, ad, dt} = VEC[v];
            case (op)
                OP_WR:  wr(ad, dt);
                OP_RD:  rd($sformatf("R%0d vec %0d", rq, v), ad, dt);
                OP_PIN: drive_pins(dt);
                default: begin
                    @(posedge clk);
                    @(negedge clk);
                    chk($sformatf("R%0d vec %0d irq", rq, v), {15'd0, irq}, dt);
                end
            endcase
        end

        // R3 pads follow registers
        chk("R3 pin_oe", pin_oe, 16'h1234);
        chk("R3 pin_out", pin_out, 16'hABCD);

        // R4 synchronizer latency, edge by edge
        wr(3'd3, 16'h0300);
        @(negedge clk);
        pin_in = 16'h0002;
        @(posedge clk); @(negedge clk); bus_addr = 3'd2; #1;
        chk("R4 din after 1 edge", bus_rdata, 16'h0000);
        @(posedge clk); @(negedge clk); bus_addr = 3'd2; #1;
        chk("R4 din after 2 edges", bus_rdata, 16'h0200);
        bus_addr = 3'd5; #1;
        chk("R4 status after 2 edges", bus_rdata, 16'h0000);
        @(posedge clk); @(negedge clk); bus_addr = 3'd5; #1;
        chk("R4 status after 3 edges", bus_rdata, 16'h0200);
        @(posedge clk); @(negedge clk);
        chk("R10 irq from rise", {15'd0, irq}, 16'h0001);

        // R9 set wins over a clear on the same edge
        drive_pins(16'h0000);
        @(negedge clk);
        pin_in = 16'h0002;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 16'h0200;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
        rd("R9 set wins", 3'd5, 16'h0200);
        wr(3'd5, 16'h0200);
        rd("R7 clear without edge", 3'd5, 16'h0000);

        // R1 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 pin_oe after reset", pin_oe, 16'h0);
        chk("R1 pin_out after reset", pin_out, 16'h0);
        chk("R1 irq after reset", {15'd0, irq}, 16'h0);
        rd("R1 rise enable after reset", 3'd3, 16'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule